// File: doc/BRIEF.md
# Nested Interrupt Priority Resolver

This block decides which exception or interrupt a processor core should take next. Requests arrive from a non-maskable input, three fault inputs, four configurable system sources (supervisor call, debug monitor, pendable service, system tick) and a parameterised set of external lines (83 by default). Each configurable source holds a 4-bit priority. Three sources have fixed levels above every configurable one: reset is most urgent, then NMI, then hard fault. A request is latched as pending. The block picks the most urgent pending source. If that source beats the current execution level, the block emits a one-cycle take strobe with the source's vector number.

The block keeps a stack of the priorities of the handlers that are running. Because of this stack, a more urgent source can nest inside a running handler. When software signals the end of a handler, the top entry is removed. If a pending source then beats the new level, it is taken at once as a tail-chained entry, with no pass through thread level. A base-priority mask sets a further floor for configurable sources.

The controller has four states:
- `ST_BOOT`: entered from reset. It announces the reset vector and then always moves to `ST_RUN`.
- `ST_RUN`: watches for a handler return or a preempting source. A return at nonzero depth moves to `ST_EXIT`. Otherwise a preempting source moves to `ST_ENTRY`.
- `ST_ENTRY`: strobes the take, pushes the priority onto the stack and clears the pending bit. It always moves back to `ST_RUN`.
- `ST_EXIT`: follows a pop. It moves to `ST_ENTRY` as a tail-chain if a source preempts, and to `ST_RUN` if none does.

Top module: `nvr_resolver`

## Requirements
- R1: After reset the block gives exactly one take with vector 1 and tail flag 0. It then sits with depth 0, `basepri_o` equal to 0 and no further take.
- R2: Vector numbers are fixed: NMI 2, hard fault 3, memory fault 4, bus fault 5, usage fault 6, supervisor call 11, debug monitor 12, pendable service 14, system tick 15, and external line n is vector 16+n.
- R3: A lower priority value is more urgent. Among pending sources of equal priority, the one with the lower vector number is taken first.
- R4: NMI outranks hard fault, and hard fault outranks every configurable priority, including value 0.
- R5: A priority is written as a byte at `cfg_addr` equal to the vector number. Only bits [7:4] of that byte count, so bytes that differ only in bits [3:0] give equal priority.
- R6: The base-priority mask is written at address 0xF0. It reads back on `basepri_o` with bits [3:0] always zero.
- R7: If the mask's upper nibble is nonzero, a configurable source whose nibble is greater than or equal to the mask's nibble is not taken. A mask of zero masks nothing. NMI and hard fault are never masked.
- R8: A pending source is taken only if it is strictly more urgent than the most urgent running handler. A source of equal or lower urgency waits. Each take raises `depth_o` by one.
- R9: A one-cycle `exc_return` pulse at nonzero depth removes the top running handler. If a pending source then beats the new level, it is taken directly with `tail_o` equal to 1.
- R10: Fault enables are written at address 0xF1: bit 0 memory, bit 1 bus, bit 2 usage. A fault with its enable set is taken at its own vector. A fault with its enable clear becomes a pending hard fault (vector 3).
- R11: Each request is taken once. Its pending bit clears on the take, and the same source is not taken again without a new request.
- R12: An `exc_return` pulse at depth 0 is ignored: the depth stays 0 and nothing is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_req | input | 1 | Non-maskable request pulse |
| fault_req | input | 3 | Fault request pulses: bit 0 memory, bit 1 bus, bit 2 usage |
| svc_req | input | 1 | Supervisor call request pulse |
| dbgmon_req | input | 1 | Debug monitor request pulse |
| pendsv_req | input | 1 | Pendable service request pulse |
| systick_req | input | 1 | System tick request pulse |
| irq_req | input | NIRQ | External line request pulses |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Write address: vector number, 0xF0 mask, 0xF1 fault enables |
| cfg_wdata | input | 8 | Write data |
| exc_return | input | 1 | Handler-finished pulse |
| take_o | output | 1 | One-cycle strobe: take an exception |
| vec_o | output | VW | Vector number of the taken exception |
| tail_o | output | 1 | The take is tail-chained after a return |
| depth_o | output | DW | Number of running handlers |
| basepri_o | output | 8 | Read-back of the base-priority mask |

## Verification
Several sources are pulsed together in the same cycle at equal programmed priorities. This shows that ties are settled by vector number and not by arrival order. The same grouping, drawn from system sources, external lines and faults, also confirms each vector position.

Staggered requests test nesting. A more urgent request that arrives while a handler runs must nest. Requests of equal or lower urgency must wait and then appear, in order, as tail-chained takes on return.

Priority bytes that differ only in their low nibble separate the implemented bits from the ignored ones. Mask values just above, equal to and below a source's level mark the edge of the mask. Faults with the enable set and clear separate a direct fault entry from escalation to hard fault.

// File: rtl/nvr_pkg.sv
package nvr_pkg;

    localparam int RW = 5;

    localparam logic [RW-1:0] RANK_NMI      = 5'd1;
    localparam logic [RW-1:0] RANK_HF       = 5'd2;
    localparam logic [RW-1:0] RANK_CFG_BASE = 5'd3;
    localparam logic [RW-1:0] RANK_NONE     = 5'd31;

    localparam int VEC_RESET  = 1;
    localparam int VEC_NMI    = 2;
    localparam int VEC_HF     = 3;
    localparam int VEC_MEMF   = 4;
    localparam int VEC_SVC    = 11;
    localparam int VEC_DBGMON = 12;
    localparam int VEC_PENDSV = 14;
    localparam int VEC_TICK   = 15;
    localparam int VEC_EXT0   = 16;

    localparam logic [7:0] ADDR_BASEPRI = 8'hF0;
    localparam logic [7:0] ADDR_FAULTEN = 8'hF1;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_RUN,
        ST_ENTRY,
        ST_EXIT
    } nvr_state_e;

    function automatic bit is_cfg_vec(input int v);
        return (v == 4) || (v == 5) || (v == 6) || (v == 11) || (v == 12) ||
               (v == 14) || (v == 15) || (v >= VEC_EXT0);
    endfunction

endpackage

// File: rtl/nvr_pend_bank.sv
module nvr_pend_bank
    import nvr_pkg::*;
#(
    parameter int NVEC = 99,
    parameter int VW   = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NVEC-1:0]          req_vec,
    input  logic [2:0]               fault_req,
    input  logic                     cfg_we,
    input  logic [7:0]               cfg_addr,
    input  logic [7:0]               cfg_wdata,
    input  logic                     clr_en,
    input  logic [VW-1:0]            clr_vec,
    output logic [NVEC-1:0]          pend,
    output logic [NVEC-1:0][RW-1:0]  rank
);

    logic [NVEC-1:0] impl_mask;
    logic [NVEC-1:0] fault_set;
    logic [NVEC-1:0] set_all;
    logic [NVEC-1:0] clr_mask;
    logic [NVEC-1:0] pend_q;
    logic [2:0]      fault_en_q;
    logic            unused_wbit;

    assign unused_wbit = cfg_wdata[3];

    for (genvar v = 0; v < NVEC; v++) begin : g_vec
        if (is_cfg_vec(v)) begin : g_cfg
            logic [3:0] nib_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    nib_q <= 4'd0;
                end else if (cfg_we && cfg_addr == 8'(v)) begin
                    nib_q <= cfg_wdata[7:4];
                end
            end
            assign rank[v]      = RANK_CFG_BASE + {1'b0, nib_q};
            assign impl_mask[v] = 1'b1;
        end else if (v == VEC_NMI) begin : g_nmi
            assign rank[v]      = RANK_NMI;
            assign impl_mask[v] = 1'b1;
        end else if (v == VEC_HF) begin : g_hf
            assign rank[v]      = RANK_HF;
            assign impl_mask[v] = 1'b1;
        end else begin : g_none
            assign rank[v]      = RANK_NONE;
            assign impl_mask[v] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_en_q <= 3'b000;
        end else if (cfg_we && cfg_addr == ADDR_FAULTEN) begin
            fault_en_q <= cfg_wdata[2:0];
        end
    end

    // A fault whose enable is clear is redirected to the hard fault bit.
    always_comb begin
        fault_set = '0;
        for (int i = 0; i < 3; i++) begin
            if (fault_req[i]) begin
                if (fault_en_q[i]) begin
                    fault_set[VEC_MEMF + i] = 1'b1;
                end else begin
                    fault_set[VEC_HF] = 1'b1;
                end
            end
        end
    end

    assign set_all  = (req_vec | fault_set) & impl_mask;
    assign clr_mask = clr_en ? (NVEC'(1) << clr_vec) : '0;

    // A new request in the clearing cycle wins over the clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_mask) | set_all;
        end
    end

    assign pend = pend_q;

    // R10: a disabled fault is pending as hard fault in the next cycle.
    p_escalate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(fault_req & ~fault_en_q)) |=> pend_q[VEC_HF]);

    // R11: without a new request, a cleared bit is low after the edge.
    p_clear_on_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_all[clr_vec]) |=> !pend_q[$past(clr_vec)]);

endmodule

// File: rtl/nvr_select.sv
module nvr_select
    import nvr_pkg::*;
#(
    parameter int NVEC = 99,
    parameter int VW   = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NVEC-1:0]          pend,
    input  logic [NVEC-1:0][RW-1:0]  rank,
    output logic                     win_valid,
    output logic [VW-1:0]            win_vec,
    output logic [RW-1:0]            win_rank
);

    // Scan upwards. The strict compare keeps the lower vector when ranks tie.
    always_comb begin
        win_rank = RANK_NONE;
        win_vec  = '0;
        for (int v = 0; v < NVEC; v++) begin
            if (pend[v] && rank[v] < win_rank) begin
                win_rank = rank[v];
                win_vec  = VW'(v);
            end
        end
        win_valid = (win_rank != RANK_NONE);
    end

    // R3: the winner is always a pending source.
    p_win_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> pend[win_vec]);

    // R3: no source with a lower vector and the same rank is passed over.
    p_tie_low_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && win_vec != '0) |-> !(pend[win_vec - VW'(1)] &&
                                           rank[win_vec - VW'(1)] == win_rank));

endmodule

// File: rtl/nvr_active_stack.sv
module nvr_active_stack
    import nvr_pkg::*;
#(
    parameter int DEPTH = 20,
    parameter int DW    = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [RW-1:0]  push_rank,
    input  logic           pop,
    output logic [RW-1:0]  top_rank,
    output logic [DW-1:0]  depth
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [RW-1:0] slot_q [DEPTH];
    logic [DW-1:0] depth_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= RANK_NONE;
            end
        end else if (push) begin
            slot_q[IW'(depth_q)] <= push_rank;
            depth_q              <= depth_q + DW'(1);
        end else if (pop) begin
            depth_q <= depth_q - DW'(1);
        end
    end

    assign top_rank = (depth_q == '0) ? RANK_NONE : slot_q[IW'(depth_q - DW'(1))];
    assign depth    = depth_q;

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (depth_q < DW'(DEPTH)));

    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (depth_q != '0));

    // R8: each nested entry is strictly more urgent than the one under it.
    p_nest_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && depth_q != '0) |-> (push_rank < top_rank));

    p_push_pop_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

endmodule

// File: rtl/nvr_resolver.sv
module nvr_resolver
    import nvr_pkg::*;
#(
    parameter int NIRQ  = 83,
    parameter int DEPTH = 20,
    localparam int NVEC = 16 + NIRQ,
    localparam int VW   = $clog2(NVEC),
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_req,
    input  logic [2:0]       fault_req,
    input  logic             svc_req,
    input  logic             dbgmon_req,
    input  logic             pendsv_req,
    input  logic             systick_req,
    input  logic [NIRQ-1:0]  irq_req,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    input  logic             exc_return,
    output logic             take_o,
    output logic [VW-1:0]    vec_o,
    output logic             tail_o,
    output logic [DW-1:0]    depth_o,
    output logic [7:0]       basepri_o
);

    nvr_state_e state_q, state_d;

    logic [NVEC-1:0]          req_vec;
    logic [NVEC-1:0]          pend;
    logic [NVEC-1:0][RW-1:0]  rank;
    logic                     win_valid;
    logic [VW-1:0]            win_vec;
    logic [RW-1:0]            win_rank;
    logic [RW-1:0]            top_rank;
    logic [DW-1:0]            depth;
    logic [3:0]               bp_nib_q;
    logic [RW-1:0]            mask_rank;
    logic [RW-1:0]            exec_rank;
    logic                     preempt;
    logic                     push;
    logic                     pop;
    logic [VW-1:0]            lat_vec_q;
    logic [RW-1:0]            lat_rank_q;
    logic                     lat_tail_q;

    always_comb begin
        req_vec                     = '0;
        req_vec[VEC_NMI]            = nmi_req;
        req_vec[VEC_SVC]            = svc_req;
        req_vec[VEC_DBGMON]         = dbgmon_req;
        req_vec[VEC_PENDSV]         = pendsv_req;
        req_vec[VEC_TICK]           = systick_req;
        req_vec[NVEC-1:VEC_EXT0]    = irq_req;
    end

    nvr_pend_bank #(.NVEC(NVEC), .VW(VW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_vec   (req_vec),
        .fault_req (fault_req),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .clr_en    (push),
        .clr_vec   (lat_vec_q),
        .pend      (pend),
        .rank      (rank)
    );

    nvr_select #(.NVEC(NVEC), .VW(VW)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .rank      (rank),
        .win_valid (win_valid),
        .win_vec   (win_vec),
        .win_rank  (win_rank)
    );

    nvr_active_stack #(.DEPTH(DEPTH), .DW(DW)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_rank (lat_rank_q),
        .pop       (pop),
        .top_rank  (top_rank),
        .depth     (depth)
    );

    // Base-priority mask: only the upper nibble is stored.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bp_nib_q <= 4'd0;
        end else if (cfg_we && cfg_addr == ADDR_BASEPRI) begin
            bp_nib_q <= cfg_wdata[7:4];
        end
    end

    assign mask_rank = (bp_nib_q == 4'd0) ? RANK_NONE : (RANK_CFG_BASE + {1'b0, bp_nib_q});
    assign exec_rank = (top_rank < mask_rank) ? top_rank : mask_rank;
    assign preempt   = win_valid && (win_rank < exec_rank);
    assign push      = (state_q == ST_ENTRY);
    assign pop       = (state_q == ST_RUN) && exc_return && (depth != '0);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = ST_RUN;
            ST_RUN: begin
                if (pop) begin
                    state_d = ST_EXIT;
                end else if (preempt) begin
                    state_d = ST_ENTRY;
                end
            end
            ST_ENTRY: state_d = ST_RUN;
            ST_EXIT:  state_d = preempt ? ST_ENTRY : ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // State register and latch of the chosen source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_BOOT;
            lat_vec_q  <= '0;
            lat_rank_q <= RANK_NONE;
            lat_tail_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_ENTRY && state_q != ST_ENTRY) begin
                lat_vec_q  <= win_vec;
                lat_rank_q <= win_rank;
                lat_tail_q <= (state_q == ST_EXIT);
            end
        end
    end

    // Outputs
    always_comb begin
        take_o = 1'b0;
        vec_o  = '0;
        tail_o = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                take_o = 1'b1;
                vec_o  = VW'(VEC_RESET);
            end
            ST_ENTRY: begin
                take_o = 1'b1;
                vec_o  = lat_vec_q;
                tail_o = lat_tail_q;
            end
            default: begin
                take_o = 1'b0;
            end
        endcase
    end

    assign depth_o   = depth;
    assign basepri_o = {bp_nib_q, 4'b0000};

    // R8: an entry is strictly more urgent than the level in force when it was chosen.
    p_take_urgent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTRY) |-> (lat_rank_q < $past(exec_rank)));

    // R7: under a nonzero mask, a configurable entry lies below the mask level.
    p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTRY && lat_rank_q >= RANK_CFG_BASE && $past(bp_nib_q) != 4'd0)
        |-> (lat_rank_q < RANK_CFG_BASE + {1'b0, $past(bp_nib_q)}));

    // R9: a tail-chained take always follows a pop.
    p_tail_after_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && tail_o) |-> ($past(state_q) == ST_EXIT));

    // R12: a return at depth 0 leaves the depth unchanged.
    p_ret_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && exc_return && depth == '0) |=> (depth == '0));

endmodule

// File: tb/tb_nvr_resolver.sv
module tb_nvr_resolver;

    localparam int CLK_PERIOD = 10;
    localparam int NIRQ       = 83;
    localparam int VW         = $clog2(16 + NIRQ);
    localparam int DW         = $clog2(20 + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            nmi_req = 1'b0;
    logic [2:0]      fault_req = 3'b000;
    logic            svc_req = 1'b0;
    logic            dbgmon_req = 1'b0;
    logic            pendsv_req = 1'b0;
    logic            systick_req = 1'b0;
    logic [NIRQ-1:0] irq_req = '0;
    logic            cfg_we = 1'b0;
    logic [7:0]      cfg_addr = 8'h00;
    logic [7:0]      cfg_wdata = 8'h00;
    logic            exc_return = 1'b0;
    logic            take_o;
    logic [VW-1:0]   vec_o;
    logic            tail_o;
    logic [DW-1:0]   depth_o;
    logic [7:0]      basepri_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        int    vec;
        bit    tail;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    nvr_resolver #(.NIRQ(NIRQ), .DEPTH(20)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_req     (nmi_req),
        .fault_req   (fault_req),
        .svc_req     (svc_req),
        .dbgmon_req  (dbgmon_req),
        .pendsv_req  (pendsv_req),
        .systick_req (systick_req),
        .irq_req     (irq_req),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .exc_return  (exc_return),
        .take_o      (take_o),
        .vec_o       (vec_o),
        .tail_o      (tail_o),
        .depth_o     (depth_o),
        .basepri_o   (basepri_o)
    );

    function automatic logic [NIRQ-1:0] line(input int n);
        return NIRQ'(1) << n;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic expect_take(input int vec, input bit tail, input string tag);
        exp_t e;
        e.vec  = vec;
        e.tail = tail;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] addr, input logic [7:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = addr;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // sys bits: 0 nmi, 1 mem fault, 2 bus fault, 3 usage fault, 4 svc, 5 dbgmon, 6 pendsv, 7 systick
    task automatic pulse(input logic [NIRQ-1:0] irqs, input logic [7:0] sys);
        @(negedge clk);
        irq_req     = irqs;
        nmi_req     = sys[0];
        fault_req   = sys[3:1];
        svc_req     = sys[4];
        dbgmon_req  = sys[5];
        pendsv_req  = sys[6];
        systick_req = sys[7];
        @(negedge clk);
        irq_req     = '0;
        nmi_req     = 1'b0;
        fault_req   = 3'b000;
        svc_req     = 1'b0;
        dbgmon_req  = 1'b0;
        pendsv_req  = 1'b0;
        systick_req = 1'b0;
        settle();
    endtask

    task automatic ret();
        @(negedge clk);
        exc_return = 1'b1;
        @(negedge clk);
        exc_return = 1'b0;
        settle();
    endtask

    // Monitor: every take is compared with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && take_o && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected take (R8/R11)", int'(vec_o), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(vec_o) == e.vec, {e.tag, " vector"}, int'(vec_o), e.vec);
                check(tail_o == e.tail, {e.tag, " tail"}, int'(tail_o), int'(e.tail));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: the reset vector is announced once after reset.
        expect_take(1, 1'b0, "R1 reset vector");
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();
        check(depth_o == 0, "R1 depth", int'(depth_o), 0);
        check(basepri_o == 8'h00, "R1 basepri", int'(basepri_o), 0);
        check(take_o == 1'b0, "R1 idle", int'(take_o), 0);

        // R12: a return with nothing running is ignored.
        ret();
        check(depth_o == 0, "R12 depth after idle return", int'(depth_o), 0);

        // R2 / R11: a single line, taken once
        cfg_write(8'd21, 8'h40);
        expect_take(21, 1'b0, "R2 line 5");
        pulse(line(5), 8'h00);
        check(depth_o == 1, "R8 depth after take", int'(depth_o), 1);
        ret();
        check(depth_o == 0, "R9 depth after return", int'(depth_o), 0);
        settle();
        check(exp_q.size() == 0, "R11 taken once", exp_q.size(), 0);

        // R2 / R3: equal priorities, lower vector first, rest tail-chained
        cfg_write(8'd11, 8'h40);
        cfg_write(8'd12, 8'h40);
        cfg_write(8'd14, 8'h40);
        cfg_write(8'd15, 8'h40);
        cfg_write(8'd18, 8'h40);
        cfg_write(8'd23, 8'h40);
        expect_take(11, 1'b0, "R3 tie svc first");
        expect_take(12, 1'b1, "R2 dbgmon vector");
        expect_take(14, 1'b1, "R2 pendsv vector");
        expect_take(15, 1'b1, "R2 systick vector");
        expect_take(18, 1'b1, "R2 line 2");
        expect_take(23, 1'b1, "R2 line 7");
        pulse(line(2) | line(7), 8'hF0);
        check(depth_o == 1, "R8 equal does not nest", int'(depth_o), 1);
        repeat (6) ret();
        check(depth_o == 0, "R9 unwound", int'(depth_o), 0);

        // R3 / R8 / R9: nesting and tail-chain ordering
        cfg_write(8'd19, 8'h80);
        cfg_write(8'd20, 8'h20);
        cfg_write(8'd22, 8'h20);
        cfg_write(8'd24, 8'h90);
        expect_take(19, 1'b0, "R3 line 3");
        pulse(line(3), 8'h00);
        expect_take(20, 1'b0, "R8 nest line 4");
        pulse(line(4), 8'h00);
        check(depth_o == 2, "R8 nested depth", int'(depth_o), 2);
        pulse(line(6), 8'h00);
        pulse(line(8), 8'h00);
        check(depth_o == 2, "R8 equal and lower wait", int'(depth_o), 2);
        expect_take(22, 1'b1, "R9 tail line 6");
        ret();
        ret();
        check(depth_o == 1, "R9 lower still waits", int'(depth_o), 1);
        expect_take(24, 1'b1, "R9 tail line 8");
        ret();
        ret();
        check(depth_o == 0, "R9 unwound 2", int'(depth_o), 0);

        // R5: low nibble ignored, so this is a tie settled by vector
        cfg_write(8'd25, 8'h3F);
        cfg_write(8'd26, 8'h30);
        expect_take(25, 1'b0, "R5 low bits ignored");
        expect_take(26, 1'b1, "R5 second");
        pulse(line(9) | line(10), 8'h00);
        ret();
        ret();

        // R4 / R10: NMI over hard fault over configurable 0
        cfg_write(8'd16, 8'h00);
        expect_take(2, 1'b0, "R4 nmi first");
        expect_take(3, 1'b1, "R4 escalated bus fault");
        expect_take(16, 1'b1, "R4 line 0 last");
        pulse(line(0), 8'h05);
        ret();
        ret();
        ret();
        check(depth_o == 0, "R4 unwound", int'(depth_o), 0);

        // R10: enabled fault at its own vector, disabled one escalates
        cfg_write(8'hF1, 8'h02);
        cfg_write(8'd5, 8'h50);
        expect_take(5, 1'b0, "R10 enabled bus fault");
        pulse('0, 8'h04);
        ret();
        expect_take(3, 1'b0, "R10 disabled mem fault");
        pulse('0, 8'h02);
        ret();

        // R6 / R7: mask boundary
        cfg_write(8'hF0, 8'h5A);
        check(basepri_o == 8'h50, "R6 basepri low nibble", int'(basepri_o), 8'h50);
        cfg_write(8'd27, 8'h50);
        cfg_write(8'd28, 8'h60);
        cfg_write(8'd29, 8'h40);
        expect_take(29, 1'b0, "R7 below mask");
        pulse(line(11) | line(12) | line(13), 8'h00);
        check(depth_o == 1, "R7 equal and above blocked", int'(depth_o), 1);
        ret();
        check(depth_o == 0, "R7 still blocked", int'(depth_o), 0);
        expect_take(2, 1'b0, "R7 nmi ignores mask");
        pulse('0, 8'h01);
        ret();
        expect_take(27, 1'b0, "R7 mask zero releases");
        expect_take(28, 1'b1, "R7 tail after release");
        cfg_write(8'hF0, 8'h00);
        settle();
        ret();
        ret();
        check(depth_o == 0, "R9 final depth", int'(depth_o), 0);

        settle();
        check(exp_q.size() == 0, "R11 all expected takes seen", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule